// File: doc/BRIEF.md
# Host-Side Packet Transfer Engine

This block is a bus-master sequencer that moves one command packet out through a two-address byte port and then collects the response packet. The port has a data address and a control address. A read of the control address returns a status byte and a write to it issues a command code. On a start pulse the engine latches a transmit length and a receive capacity. It fetches the outgoing bytes from a local transmit buffer, steps through a fixed handshake on the port, stores the incoming bytes into a local receive buffer, and ends with a one-cycle completion pulse that carries an error code and the response size.

Every step of the handshake is a wait for a masked status pattern. The status is read at once. On a mismatch the engine reads it again, and a per-wait cycle timer bounds the wait. The ready wait and all other waits have separate limits. Two further checks guard the exchange. The send opens with a defensive cancel code. The receive checks the mode byte and the closing marker byte, then takes a big-endian 32-bit length from the response header.

Status bit positions: output-full is bit 0, input-full is bit 1, frame flag is bit 2, ready is bit 4 and accept-data is bit 5. Command codes: cancel is 0x22, normal is 0x01 and end-of-command is 0x03. Port address 0 is data and port address 1 is control.

State flow:
- Send: S_IDLE → S_CANCEL → ready wait (S_RDY_RD/S_RDY_EV, with drain S_DRN_RD/S_DRN_EV) → S_IBF_RD/S_IBF_EV → S_NORMAL → S_IBR_RD/S_IBR_EV → loop of S_TXW_RD/S_TXW_EV and S_TXBYTE → S_EOC.
- Receive: S_EOC → S_CAP → S_F0A_RD/S_F0A_EV → S_MODE_RD/S_MODE_EV → loop of S_OBF_RD/S_OBF_EV and S_DAT_RD/S_DAT_EV → optional S_F0B_RD/S_F0B_EV → S_END_RD/S_END_EV → S_SIZE → S_DONE → S_IDLE.
- Any failed check jumps to S_DONE.

Top module: `pkt_xfer_engine`

## Requirements
- R1: A start pulse in idle latches the length and capacity, and on the next cycle the engine writes 0x22 to control address 1. A start pulse while a transfer runs is ignored. No port access happens in idle.
- R2: The ready wait reads status and passes on ready (bit 4). If output-full (bit 0) is set, the engine first reads the data address, and bit 4 of that data value decides instead.
- R3: After ready, the engine waits for input-full (bit 1) clear, writes 0x01 to address 1, then waits for accept-data (bit 5) set.
- R4: For each payload byte, the engine waits for input-full clear and then writes transmit-buffer entry i (i = 0 to length-1, in order) to address 0. After the last byte it waits for input-full clear once more and writes 0x03 to address 1.
- R5: Each wait samples status immediately and re-polls on mismatch. It fails with code 1 once its cycle timer reaches its limit: RDY_TMO for the ready wait, GEN_TMO for the others. A ready wait that never succeeds makes RDY_TMO/2+1 status reads.
- R6: After end-of-command, a capacity below 6 fails with code 4 before any receive access.
- R7: The receive waits for the frame flag (bit 2), reads data, and requires 0x01. Any other value fails with code 2.
- R8: Per byte, the engine waits for output-full. If the frame flag is set in the same status, the loop stops. Otherwise it reads data and writes it to receive address 0, 1, 2 and so on, storing at most capacity bytes.
- R9: If the loop ended without seeing the frame flag, the engine waits for it. It then reads data and requires 0x03, failing with code 3 otherwise.
- R10: The size is the 32-bit value in received bytes 2..5, byte 2 most significant. A size above the capacity fails with code 4. Otherwise the result has code 0 and the size is reported.
- R11: Completion is a one-cycle done pulse. The error code is 0 none, 1 busy timeout, 2 bad mode byte, 3 bad end byte, 4 size error. The reported size is 0 on any error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, taken only in idle |
| tx_len | input | LEN_W | Payload length to send |
| rx_cap | input | LEN_W | Receive buffer capacity |
| tx_addr | output | LEN_W | Transmit buffer read address |
| tx_rdata | input | 8 | Transmit buffer read data, same cycle |
| bus_en | output | 1 | Port access strobe, one cycle per access |
| bus_we | output | 1 | Port access is a write |
| bus_addr | output | 1 | Port address, 0 data, 1 control |
| bus_wdata | output | 8 | Port write data |
| bus_rdata | input | 8 | Port read data, valid the cycle after a read strobe |
| rx_we | output | 1 | Receive buffer write strobe |
| rx_addr | output | LEN_W | Receive buffer write address |
| rx_wdata | output | 8 | Receive buffer write data |
| done | output | 1 | Completion pulse |
| err_code | output | 3 | Completion error code |
| rx_size | output | 32 | Response size from header, 0 on error |

## Verification
Two decisions can fall on the same status sample. In the receive loop, output-full together with the frame flag means the byte must not be stored and the loop must end. In the ready wait, output-full together with a status lacking ready means the drain read, not the status, decides. The port model in the bench raises output-full and the frame flag together on the sample after the last response byte. Response lengths are swept below, equal to and above the capacity, and the bench judges the result by the count and content of receive-buffer writes and by the error code. A stale output-full at the first ready sample, with the drained value carrying or lacking ready, is judged by whether the send proceeds.

// File: rtl/pkt_xfer_pkg.sv
package pkt_xfer_pkg;

    localparam int unsigned ST_OBF = 0;
    localparam int unsigned ST_IBF = 1;
    localparam int unsigned ST_F0  = 2;
    localparam int unsigned ST_RDY = 4;
    localparam int unsigned ST_IBR = 5;

    localparam logic [7:0] CODE_CANCEL = 8'h22;
    localparam logic [7:0] CODE_NORMAL = 8'h01;
    localparam logic [7:0] CODE_EOC    = 8'h03;

    localparam logic PORT_DATA = 1'b0;
    localparam logic PORT_CTRL = 1'b1;

    localparam int unsigned HDR_BYTES = 6;

    typedef enum logic [2:0] {
        ERR_NONE = 3'd0,
        ERR_BUSY = 3'd1,
        ERR_MODE = 3'd2,
        ERR_END  = 3'd3,
        ERR_SIZE = 3'd4
    } err_e;

    typedef enum logic [4:0] {
        S_IDLE, S_CANCEL,
        S_RDY_RD, S_RDY_EV, S_DRN_RD, S_DRN_EV,
        S_IBF_RD, S_IBF_EV, S_NORMAL, S_IBR_RD, S_IBR_EV,
        S_TXW_RD, S_TXW_EV, S_TXBYTE, S_EOC,
        S_CAP, S_F0A_RD, S_F0A_EV, S_MODE_RD, S_MODE_EV,
        S_OBF_RD, S_OBF_EV, S_DAT_RD, S_DAT_EV,
        S_F0B_RD, S_F0B_EV, S_END_RD, S_END_EV,
        S_SIZE, S_DONE
    } state_e;

endpackage

// File: rtl/pkt_xfer_poll.sv
module pkt_xfer_poll #(
    parameter int unsigned RDY_TMO = 1000,
    parameter int unsigned GEN_TMO = 4000,
    parameter int unsigned TMO_W   = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic restart,
    input  logic use_rdy,
    output logic expired
);
    localparam logic [TMO_W-1:0] RDY_LIM = TMO_W'(RDY_TMO);
    localparam logic [TMO_W-1:0] GEN_LIM = TMO_W'(GEN_TMO);

    logic [TMO_W-1:0] timer;
    logic [TMO_W-1:0] limit;

    assign limit   = use_rdy ? RDY_LIM : GEN_LIM;
    assign expired = (timer >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timer <= '0;
        end else if (!active || restart) begin
            timer <= '0;
        end else if (timer != '1) begin
            timer <= timer + 1'b1;
        end
    end

    // R5: an evaluation fails at the limit; a drain detour may add two more cycles
    p_timer_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (timer <= limit + TMO_W'(3)));

    p_timer_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (timer == '0));

endmodule

// File: rtl/pkt_xfer_hdr.sv
module pkt_xfer_hdr #(
    parameter int unsigned LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             we,
    input  logic [LEN_W-1:0] idx,
    input  logic [7:0]       data,
    output logic [31:0]      size
);
    localparam logic [LEN_W-1:0] FIRST = LEN_W'(2);
    localparam logic [LEN_W-1:0] LAST  = LEN_W'(5);

    logic in_field;
    assign in_field = (idx >= FIRST) && (idx <= LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            size <= '0;
        end else if (clr) begin
            size <= '0;
        end else if (we && in_field) begin
            size <= {size[23:0], data};
        end
    end

    // R10: the byte at offset 5 lands in the least significant position
    p_hdr_lsb_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !clr && idx == LAST) |=> (size[7:0] == $past(data)));

    p_hdr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!we && !clr) |=> $stable(size));

endmodule

// File: rtl/pkt_xfer_engine.sv
module pkt_xfer_engine
    import pkt_xfer_pkg::*;
#(
    parameter int unsigned LEN_W   = 8,
    parameter int unsigned RDY_TMO = 1000,
    parameter int unsigned GEN_TMO = 4000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] tx_len,
    input  logic [LEN_W-1:0] rx_cap,
    output logic [LEN_W-1:0] tx_addr,
    input  logic [7:0]       tx_rdata,
    output logic             bus_en,
    output logic             bus_we,
    output logic             bus_addr,
    output logic [7:0]       bus_wdata,
    input  logic [7:0]       bus_rdata,
    output logic             rx_we,
    output logic [LEN_W-1:0] rx_addr,
    output logic [7:0]       rx_wdata,
    output logic             done,
    output logic [2:0]       err_code,
    output logic [31:0]      rx_size
);
    localparam int unsigned TMO_MAX = (RDY_TMO > GEN_TMO) ? RDY_TMO : GEN_TMO;
    localparam int unsigned TMO_W   = $clog2(TMO_MAX + 4) + 1;
    localparam logic [LEN_W-1:0] MIN_CAP = LEN_W'(HDR_BYTES);

    state_e state, nxt;

    logic [LEN_W-1:0] len_q, cap_q, tx_idx, rx_idx;
    err_e             err_q;
    logic [31:0]      size_q;

    logic  fail;
    err_e  fail_code;
    logic  adv;
    logic  tmo;
    logic  wait_act;
    logic  wait_rdy;
    logic  launch;
    logic [31:0] hdr_size;
    logic [LEN_W:0] rx_next;

    assign launch  = (state == S_IDLE) && start;
    assign rx_next = {1'b0, rx_idx} + 1'b1;

    always_comb begin
        wait_rdy = (state == S_RDY_RD) || (state == S_RDY_EV) ||
                   (state == S_DRN_RD) || (state == S_DRN_EV);
        wait_act = wait_rdy ||
                   (state == S_IBF_RD) || (state == S_IBF_EV) ||
                   (state == S_IBR_RD) || (state == S_IBR_EV) ||
                   (state == S_TXW_RD) || (state == S_TXW_EV) ||
                   (state == S_F0A_RD) || (state == S_F0A_EV) ||
                   (state == S_OBF_RD) || (state == S_OBF_EV) ||
                   (state == S_F0B_RD) || (state == S_F0B_EV);
    end

    pkt_xfer_poll #(
        .RDY_TMO (RDY_TMO),
        .GEN_TMO (GEN_TMO),
        .TMO_W   (TMO_W)
    ) u_poll (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (wait_act),
        .restart (adv),
        .use_rdy (wait_rdy),
        .expired (tmo)
    );

    pkt_xfer_hdr #(
        .LEN_W (LEN_W)
    ) u_hdr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (launch),
        .we    (state == S_DAT_EV),
        .idx   (rx_idx),
        .data  (bus_rdata),
        .size  (hdr_size)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Next state and failure decisions
    always_comb begin
        nxt       = state;
        fail      = 1'b0;
        fail_code = ERR_NONE;
        adv       = 1'b0;
        unique case (state)
            S_IDLE:   if (start) nxt = S_CANCEL;
            S_CANCEL: nxt = S_RDY_RD;
            S_RDY_RD: nxt = S_RDY_EV;
            S_RDY_EV: begin
                if (bus_rdata[ST_OBF]) begin
                    nxt = S_DRN_RD;
                end else if (bus_rdata[ST_RDY]) begin
                    adv = 1'b1;
                    nxt = S_IBF_RD;
                end else if (tmo) begin
                    fail = 1'b1; fail_code = ERR_BUSY;
                end else begin
                    nxt = S_RDY_RD;
                end
            end
            S_DRN_RD: nxt = S_DRN_EV;
            S_DRN_EV: begin
                if (bus_rdata[ST_RDY]) begin
                    adv = 1'b1;
                    nxt = S_IBF_RD;
                end else if (tmo) begin
                    fail = 1'b1; fail_code = ERR_BUSY;
                end else begin
                    nxt = S_RDY_RD;
                end
            end
            S_IBF_RD: nxt = S_IBF_EV;
            S_IBF_EV: begin
                if (!bus_rdata[ST_IBF]) begin
                    adv = 1'b1;
                    nxt = S_NORMAL;
                end else if (tmo) begin
                    fail = 1'b1; fail_code = ERR_BUSY;
                end else begin
                    nxt = S_IBF_RD;
                end
            end
            S_NORMAL: nxt = S_IBR_RD;
            S_IBR_RD: nxt = S_IBR_EV;
            S_IBR_EV: begin
                if (bus_rdata[ST_IBR]) begin
                    adv = 1'b1;
                    nxt = S_TXW_RD;
                end else if (tmo) begin
                    fail = 1'b1; fail_code = ERR_BUSY;
                end else begin
                    nxt = S_IBR_RD;
                end
            end
            S_TXW_RD: nxt = S_TXW_EV;
            S_TXW_EV: begin
                if (!bus_rdata[ST_IBF]) begin
                    adv = 1'b1;
                    nxt = (tx_idx < len_q) ? S_TXBYTE : S_EOC;
                end else if (tmo) begin
                    fail = 1'b1; fail_code = ERR_BUSY;
                end else begin
                    nxt = S_TXW_RD;
                end
            end
            S_TXBYTE: nxt = S_TXW_RD;
            S_EOC:    nxt = S_CAP;
            S_CAP: begin
                if (cap_q < MIN_CAP) begin
                    fail = 1'b1; fail_code = ERR_SIZE;
                end else begin
                    nxt = S_F0A_RD;
                end
            end
            S_F0A_RD: nxt = S_F0A_EV;
            S_F0A_EV: begin
                if (bus_rdata[ST_F0]) begin
                    adv = 1'b1;
                    nxt = S_MODE_RD;
                end else if (tmo) begin
                    fail = 1'b1; fail_code = ERR_BUSY;
                end else begin
                    nxt = S_F0A_RD;
                end
            end
            S_MODE_RD: nxt = S_MODE_EV;
            S_MODE_EV: begin
                if (bus_rdata == CODE_NORMAL) begin
                    nxt = S_OBF_RD;
                end else begin
                    fail = 1'b1; fail_code = ERR_MODE;
                end
            end
            S_OBF_RD: nxt = S_OBF_EV;
            S_OBF_EV: begin
                if (bus_rdata[ST_OBF]) begin
                    adv = 1'b1;
                    nxt = bus_rdata[ST_F0] ? S_END_RD : S_DAT_RD;
                end else if (tmo) begin
                    fail = 1'b1; fail_code = ERR_BUSY;
                end else begin
                    nxt = S_OBF_RD;
                end
            end
            S_DAT_RD: nxt = S_DAT_EV;
            S_DAT_EV: nxt = (rx_next < {1'b0, cap_q}) ? S_OBF_RD : S_F0B_RD;
            S_F0B_RD: nxt = S_F0B_EV;
            S_F0B_EV: begin
                if (bus_rdata[ST_F0]) begin
                    adv = 1'b1;
                    nxt = S_END_RD;
                end else if (tmo) begin
                    fail = 1'b1; fail_code = ERR_BUSY;
                end else begin
                    nxt = S_F0B_RD;
                end
            end
            S_END_RD: nxt = S_END_EV;
            S_END_EV: begin
                if (bus_rdata == CODE_EOC) begin
                    nxt = S_SIZE;
                end else begin
                    fail = 1'b1; fail_code = ERR_END;
                end
            end
            S_SIZE: begin
                if (hdr_size > 32'(cap_q)) begin
                    fail = 1'b1; fail_code = ERR_SIZE;
                end else begin
                    nxt = S_DONE;
                end
            end
            S_DONE:  nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
        if (fail) nxt = S_DONE;
    end

    // Outputs
    always_comb begin
        bus_en    = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = PORT_CTRL;
        bus_wdata = 8'h00;
        rx_we     = 1'b0;
        done      = 1'b0;
        unique case (state)
            S_CANCEL: begin
                bus_en = 1'b1; bus_we = 1'b1; bus_wdata = CODE_CANCEL;
            end
            S_NORMAL: begin
                bus_en = 1'b1; bus_we = 1'b1; bus_wdata = CODE_NORMAL;
            end
            S_EOC: begin
                bus_en = 1'b1; bus_we = 1'b1; bus_wdata = CODE_EOC;
            end
            S_TXBYTE: begin
                bus_en = 1'b1; bus_we = 1'b1;
                bus_addr = PORT_DATA; bus_wdata = tx_rdata;
            end
            S_RDY_RD, S_IBF_RD, S_IBR_RD, S_TXW_RD,
            S_F0A_RD, S_OBF_RD, S_F0B_RD: begin
                bus_en = 1'b1;
            end
            S_DRN_RD, S_MODE_RD, S_DAT_RD, S_END_RD: begin
                bus_en = 1'b1; bus_addr = PORT_DATA;
            end
            S_DAT_EV: rx_we = 1'b1;
            S_DONE:   done  = 1'b1;
            default: ;
        endcase
    end

    assign tx_addr  = tx_idx;
    assign rx_addr  = rx_idx;
    assign rx_wdata = bus_rdata;
    assign err_code = err_q;
    assign rx_size  = size_q;

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q  <= '0;
            cap_q  <= '0;
            tx_idx <= '0;
            rx_idx <= '0;
            err_q  <= ERR_NONE;
            size_q <= '0;
        end else begin
            if (launch) begin
                len_q  <= tx_len;
                cap_q  <= rx_cap;
                tx_idx <= '0;
                rx_idx <= '0;
                err_q  <= ERR_NONE;
                size_q <= '0;
            end
            if (state == S_TXBYTE) tx_idx <= tx_idx + 1'b1;
            if (state == S_DAT_EV) rx_idx <= rx_idx + 1'b1;
            if (fail) err_q <= fail_code;
            if (state == S_SIZE && !fail) size_q <= hdr_size;
        end
    end

    p_cancel_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && start) |=>
            (bus_en && bus_we && bus_addr == PORT_CTRL && bus_wdata == CODE_CANCEL));

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> !bus_en);

    p_ctrl_codes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_we && bus_addr == PORT_CTRL) |->
            (bus_wdata == CODE_CANCEL || bus_wdata == CODE_NORMAL || bus_wdata == CODE_EOC));

    p_rx_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_we |-> (rx_addr < cap_q));

    p_ok_size_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_code == ERR_NONE) |-> (rx_size <= 32'(cap_q)));

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_err_size_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_code != ERR_NONE) |-> (rx_size == 32'd0));

endmodule

// File: tb/pkt_xfer_engine_bench.sv
module pkt_xfer_engine_bench;
    localparam int LEN_W   = 8;
    localparam int RDY_TMO = 20;
    localparam int GEN_TMO = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [LEN_W-1:0] tx_len = '0;
    logic [LEN_W-1:0] rx_cap = '0;
    logic [LEN_W-1:0] tx_addr;
    logic [7:0]       tx_rdata;
    logic             bus_en, bus_we, bus_addr;
    logic [7:0]       bus_wdata;
    logic [7:0]       bus_rdata = 8'h00;
    logic             rx_we;
    logic [LEN_W-1:0] rx_addr;
    logic [7:0]       rx_wdata;
    logic             done;
    logic [2:0]       err_code;
    logic [31:0]      rx_size;

    always #4 clk = ~clk;

    pkt_xfer_engine #(.LEN_W(LEN_W), .RDY_TMO(RDY_TMO), .GEN_TMO(GEN_TMO)) u_pkt_xfer_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_len(tx_len), .rx_cap(rx_cap),
        .tx_addr(tx_addr), .tx_rdata(tx_rdata),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_we(rx_we), .rx_addr(rx_addr), .rx_wdata(rx_wdata),
        .done(done), .err_code(err_code), .rx_size(rx_size)
    );

    // transmit buffer contents are arithmetic
    int tx_seed = 0;
    assign tx_rdata = 8'((int'(tx_addr) * 7 + tx_seed) & 255);

    // port model configuration
    int         cfg_rdy_delay, cfg_ibf_delay, cfg_nresp;
    bit         cfg_stale;
    logic [7:0] cfg_drain, cfg_mode, cfg_end;
    logic [7:0] resp [16];
    bit         mclr = 1'b0;

    // port model state
    int         rdy_reads, ibf_cnt, rptr, stat_reads, rx_dreads, wcnt, rxw_cnt;
    bit         stale_pend, rx_phase, rx_stage;
    logic [7:0] wlog_d [64];
    logic       wlog_a [64];
    logic [7:0] rx_mem [256];

    function automatic logic [7:0] stat_now();
        logic [7:0] s;
        if (!rx_phase) begin
            s = 8'h20;
            if (rdy_reads >= cfg_rdy_delay) s[4] = 1'b1;
            if (ibf_cnt > 0) s[1] = 1'b1;
            if (stale_pend) s[0] = 1'b1;
        end else if (!rx_stage) begin
            s = 8'h04;
        end else if (rptr < cfg_nresp) begin
            s = 8'h01;
        end else begin
            s = 8'h05;
        end
        return s;
    endfunction

    always @(posedge clk) begin
        if (mclr) begin
            rdy_reads <= 0; ibf_cnt <= 0; rptr <= 0; stat_reads <= 0;
            rx_dreads <= 0; wcnt <= 0; rxw_cnt <= 0;
            stale_pend <= cfg_stale; rx_phase <= 1'b0; rx_stage <= 1'b0;
        end else begin
            if (bus_en && !bus_we && bus_addr) begin
                bus_rdata  <= stat_now();
                stat_reads <= stat_reads + 1;
                if (!rx_phase) rdy_reads <= rdy_reads + 1;
                if (ibf_cnt > 0) ibf_cnt <= ibf_cnt - 1;
            end else if (bus_en && !bus_we) begin
                if (!rx_phase) begin
                    bus_rdata  <= cfg_drain;
                    stale_pend <= 1'b0;
                end else begin
                    rx_dreads <= rx_dreads + 1;
                    if (!rx_stage) begin
                        bus_rdata <= cfg_mode;
                        rx_stage  <= 1'b1;
                    end else if (rptr < cfg_nresp) begin
                        bus_rdata <= resp[rptr];
                        rptr      <= rptr + 1;
                    end else begin
                        bus_rdata <= cfg_end;
                    end
                end
            end else if (bus_en && bus_we) begin
                if (wcnt < 64) begin
                    wlog_a[wcnt] <= bus_addr;
                    wlog_d[wcnt] <= bus_wdata;
                end
                wcnt <= wcnt + 1;
                if (!bus_addr) ibf_cnt <= cfg_ibf_delay;
                if (bus_addr && bus_wdata == 8'h03) rx_phase <= 1'b1;
            end
            if (rx_we) begin
                rx_mem[rx_addr] <= rx_wdata;
                rxw_cnt <= rxw_cnt + 1;
            end
        end
    end

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;
    int cyc = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !finished) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: act=%0d exp<=%0d cycles", cyc, 150000);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_tests = n_tests + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    logic [2:0]  got_err;
    logic [31:0] got_size;
    int          got_cycles;

    task automatic setup(input int nr, input int sz, input logic [7:0] mode,
                         input logic [7:0] endb, input int rdyd, input bit stale,
                         input logic [7:0] dv, input int ibfd);
        cfg_nresp = nr; cfg_mode = mode; cfg_end = endb;
        cfg_rdy_delay = rdyd; cfg_stale = stale; cfg_drain = dv; cfg_ibf_delay = ibfd;
        for (int i = 0; i < 16; i++) resp[i] = 8'((i * 13 + nr + 5) & 255);
        resp[2] = 8'((sz >> 24) & 255);
        resp[3] = 8'((sz >> 16) & 255);
        resp[4] = 8'((sz >> 8) & 255);
        resp[5] = 8'(sz & 255);
    endtask

    task automatic launch(input int len, input int cap);
        @(negedge clk);
        mclr = 1'b1;
        @(negedge clk);
        mclr = 1'b0;
        tx_len = LEN_W'(len);
        rx_cap = LEN_W'(cap);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        got_cycles = 0;
        while (!done && got_cycles < 3000) begin
            @(negedge clk);
            got_cycles++;
        end
        got_err  = err_code;
        got_size = rx_size;
        chk(done == 1'b1, "R11 done seen", done, 1);
        @(negedge clk);
        chk(done == 1'b0, "R11 done single pulse", done, 0);
    endtask

    task automatic check_send(input int len);
        chk(wcnt == len + 3, "R4 write count", wcnt, len + 3);
        chk(wlog_a[0] == 1'b1 && wlog_d[0] == 8'h22, "R1 cancel first", wlog_d[0], 8'h22);
        chk(wlog_a[1] == 1'b1 && wlog_d[1] == 8'h01, "R3 normal code", wlog_d[1], 8'h01);
        for (int i = 0; i < len; i++) begin
            chk(wlog_a[2+i] == 1'b0 && wlog_d[2+i] == 8'((i * 7 + tx_seed) & 255),
                "R4 payload byte", wlog_d[2+i], (i * 7 + tx_seed) & 255);
        end
        chk(wlog_a[len+2] == 1'b1 && wlog_d[len+2] == 8'h03, "R4 end code",
            wlog_d[len+2], 8'h03);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(done == 1'b0 && bus_en == 1'b0, "R1 reset quiet", bus_en, 0);
        chk(err_code == 3'd0 && rx_size == 32'd0, "R11 reset outputs", err_code, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(bus_en == 1'b0, "R1 idle no access", bus_en, 0);

        // sweep: capacity, response length, size variant
        for (int cap = 4; cap <= 12; cap++) begin
            for (int nr = 6; nr <= 10; nr++) begin
                for (int v = 0; v < 2; v++) begin
                    int len, sz, e, nst;
                    len = (cap + nr + v) % 6;
                    sz = (v == 0) ? nr : cap + 1;
                    tx_seed = cap * 3 + nr;
                    setup(nr, sz, 8'h01, 8'h03, 3, 1'b0, 8'h00, 2);
                    launch(len, cap);
                    wait_done();
                    check_send(len);
                    if (cap < 6) e = 4;
                    else if (nr > cap) e = 1;
                    else if (sz > cap) e = 4;
                    else e = 0;
                    nst = (cap < 6) ? 0 : ((nr < cap) ? nr : cap);
                    chk(got_err == 3'(e), "R10 sweep error code", got_err, e);
                    chk(got_size == ((e == 0) ? 32'(sz) : 32'd0), "R10 sweep size",
                        got_size, (e == 0) ? sz : 0);
                    chk(rxw_cnt == nst, "R8 stored byte count", rxw_cnt, nst);
                    for (int i = 0; i < nst; i++)
                        chk(rx_mem[i] == resp[i], "R8 stored byte", rx_mem[i], resp[i]);
                    if (cap < 6)
                        chk(rx_dreads == 0, "R6 no receive access", rx_dreads, 0);
                end
            end
        end

        // ready wait timeout
        setup(8, 8, 8'h01, 8'h03, 100000, 1'b0, 8'h00, 0);
        launch(2, 10);
        wait_done();
        chk(got_err == 3'd1, "R5 ready timeout code", got_err, 1);
        chk(stat_reads == RDY_TMO / 2 + 1, "R5 ready poll count", stat_reads, RDY_TMO / 2 + 1);
        chk(wcnt == 1, "R5 only cancel written", wcnt, 1);

        // general wait timeout while input stays full after a data byte
        setup(8, 8, 8'h01, 8'h03, 0, 1'b0, 8'h00, 100000);
        launch(2, 10);
        wait_done();
        chk(got_err == 3'd1, "R5 general timeout code", got_err, 1);
        chk(wcnt == 3, "R5 stop after first byte", wcnt, 3);

        // stale output-full, drained value carries ready, status never ready
        setup(8, 8, 8'h01, 8'h03, 100000, 1'b1, 8'h10, 0);
        launch(1, 10);
        wait_done();
        chk(got_err == 3'd0, "R2 drained ready accepted", got_err, 0);
        chk(stale_pend == 1'b0, "R2 drain read made", stale_pend, 0);

        // stale output-full, drained value without ready, status ready later
        setup(8, 8, 8'h01, 8'h03, 2, 1'b1, 8'h00, 0);
        launch(3, 10);
        wait_done();
        chk(got_err == 3'd0, "R2 drain then status ready", got_err, 0);
        check_send(3);

        // bad mode byte
        setup(8, 8, 8'h02, 8'h03, 0, 1'b0, 8'h00, 1);
        launch(2, 10);
        wait_done();
        chk(got_err == 3'd2, "R7 bad mode", got_err, 2);
        chk(rxw_cnt == 0, "R7 nothing stored", rxw_cnt, 0);

        // bad end byte
        setup(7, 7, 8'h01, 8'h05, 0, 1'b0, 8'h00, 1);
        launch(2, 10);
        wait_done();
        chk(got_err == 3'd3, "R9 bad end", got_err, 3);
        chk(got_size == 32'd0, "R11 size zero on error", got_size, 0);

        // high header byte makes size exceed capacity
        setup(8, 32'h0100_0008, 8'h01, 8'h03, 0, 1'b0, 8'h00, 0);
        launch(0, 12);
        wait_done();
        chk(got_err == 3'd4, "R10 big-endian high byte", got_err, 4);
        check_send(0);

        // start while busy is ignored
        setup(8, 8, 8'h01, 8'h03, 4, 1'b0, 8'h00, 2);
        launch(2, 10);
        repeat (5) @(negedge clk);
        tx_len = 8'd5;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        chk(got_err == 3'd0, "R1 busy start ignored code", got_err, 0);
        check_send(2);
        chk(got_size == 32'd8, "R10 size after ignored start", got_size, 8);
        repeat (3) @(negedge clk);
        chk(bus_en == 1'b0, "R1 idle after done", bus_en, 0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule